// File: doc/BRIEF.md
# Input Port Packet Buffer Allocator

This block sits at one input port of a router with three inputs and three outputs. It watches the incoming word stream for a word flagged as the start of a packet. When such a word arrives and the port is idle, it claims the lowest-numbered free slot in a store of four whole-packet slots. It then writes all twelve words of the packet into that slot. Even-numbered and odd-numbered words go to two separate banks. The third word of the packet (word 2) carries the destination output port in its two low bits.

After the last word, the block holds the slot. It forms a six-bit request record from the destination, this port's number and the slot index, and queues the record in a four-entry request FIFO. The output side's transmit controller pops the record, reads the packet back through a word read port, and pulses a release with the slot index to return the slot to the free pool.

A start word that arrives while a packet is still being written is refused and flagged with a wait pulse. A start word that arrives while every slot is held is refused and flagged with an error pulse.

The controller is a three-state machine:
- IDLE waits for a start word. On a start word with a free slot it goes to WRITE. On a start word with no free slot it flags the error and stays in IDLE.
- WRITE counts words 1 to 11. It goes to COMMIT on word 11.
- COMMIT settles the slot and queues the record. It always returns to IDLE after one cycle.

Top module: `ipba_top`

## Requirements
- R1: After reset, `req_valid`, `req_rec`, `wait_o` and `err_o` are 0, and all four slots are free.
- R2: A start word (`in_valid` and `in_first`) taken in IDLE claims the lowest-numbered free slot. The first packet after reset uses slot 0.
- R3: The twelve words of a packet are stored in order. Word k of slot s reads back on `rd_word` when `rd_slot`=s and `rd_idx`=k. Even k are held in one bank and odd k in the other.
- R4: One cycle after the clock edge that takes word 11, the request record `{dest[1:0], port[1:0], slot[1:0]}` (bits 5:4, 3:2, 1:0) is queued. `dest` is bits [1:0] of word 2 and `port` is parameter `PORT_ID`.
- R5: A destination value of 3 is invalid. No record is queued, and the slot returns to free.
- R6: A start word that arrives during WRITE or COMMIT is not stored. `wait_o` pulses for one cycle in the cycle after it, and the packet in progress completes unchanged.
- R7: A start word in IDLE with all four slots held produces a one-cycle `err_o` pulse in the next cycle. Nothing is stored and nothing is queued.
- R8: A `rel_valid` pulse with `rel_slot` naming a held slot frees that slot, so that a later start word can claim it.
- R9: Records leave the FIFO in arrival order. `req_pop` with `req_valid` removes the head in one cycle, and the FIFO holds up to four records.
- R10: Words without `in_first` that arrive while in IDLE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word valid |
| in_first | input | 1 | Marks the start word of a packet |
| in_word | input | 16 | Incoming packet word |
| wait_o | output | 1 | Pulse: start word refused while busy |
| err_o | output | 1 | Pulse: start word refused, all slots held |
| rel_valid | input | 1 | Release strobe from output side |
| rel_slot | input | 2 | Slot index being released |
| rd_slot | input | 2 | Read port slot index |
| rd_idx | input | 4 | Read port word index 0..11 |
| rd_word | output | 16 | Word read from the store |
| req_valid | output | 1 | Request FIFO not empty |
| req_rec | output | 6 | Head request record {dest, port, slot} |
| req_pop | input | 1 | Remove the head record |

## Verification
The assertions check every cycle that:
- `wait_o` and `err_o` never rise together;
- an error follows only a cycle in which every slot was held;
- a newly visible record follows a COMMIT cycle;
- a claimed slot was free;
- at most one slot is being filled;
- the FIFO is never pushed when full.

Only the directed scenarios can show the actual data path. These are:
- which slot a packet lands in;
- the stored word contents;
- the exact record values and their order;
- that a refused or stray word leaves the store untouched;
- that a released or discarded slot is reused.

// File: rtl/ipba_pkg.sv
package ipba_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_FILL = 2'd1,
        SLOT_HELD = 2'd2
    } slot_st_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_COMMIT = 2'd2
    } fsm_e;

    typedef struct packed {
        logic [1:0] dest;
        logic [1:0] port;
        logic [1:0] slot;
    } req_rec_t;

    localparam logic [1:0] DEST_INVALID = 2'd3;
endpackage

// File: rtl/ipba_slot_alloc.sv
module ipba_slot_alloc
    import ipba_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          fin,
    input  logic          fin_keep,
    input  logic [SW-1:0] fin_slot,
    input  logic          rel_valid,
    input  logic [SW-1:0] rel_slot,
    output logic [SW-1:0] grant,
    output logic          free_any,
    output logic          all_held
);
    slot_st_e          st [SLOTS];
    logic [SLOTS-1:0]  fill_vec;

    // lowest-numbered free slot wins
    always_comb begin
        grant    = '0;
        free_any = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (st[i] == SLOT_FREE) begin
                grant    = SW'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        all_held = 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
            fill_vec[i] = (st[i] == SLOT_FILL);
            if (st[i] != SLOT_HELD) all_held = 1'b0;
        end
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st[g] <= SLOT_FREE;
                end else begin
                    unique case (st[g])
                        SLOT_FREE: if (alloc && grant == SW'(g)) st[g] <= SLOT_FILL;
                        SLOT_FILL: if (fin && fin_slot == SW'(g))
                                       st[g] <= fin_keep ? SLOT_HELD : SLOT_FREE;
                        SLOT_HELD: if (rel_valid && rel_slot == SW'(g)) st[g] <= SLOT_FREE;
                        default:   st[g] <= SLOT_FREE;
                    endcase
                end
            end
        end
    endgenerate

    AST_GRANT_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (free_any && st[grant] == SLOT_FREE)); // R2
    AST_ONE_FILLING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_vec)); // R6
endmodule

// File: rtl/ipba_bank_store.sv
module ipba_bank_store #(
    parameter int DATA_W    = 16,
    parameter int SLOTS     = 4,
    parameter int PKT_WORDS = 12,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW   = $clog2(PKT_WORDS),
    localparam int HALF = (PKT_WORDS + 1) / 2,
    localparam int AW   = $clog2(SLOTS * HALF)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_slot,
    input  logic [CW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SW-1:0]     rd_slot,
    input  logic [CW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] bank_q [2];

    assign wr_addr = AW'(int'(wr_slot) * HALF + int'(wr_idx >> 1));
    assign rd_addr = AW'(int'(rd_slot) * HALF + int'(rd_idx >> 1));

    // bank 0 holds even word positions, bank 1 odd ones
    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            logic [DATA_W-1:0] mem [SLOTS * HALF];
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx[0] == 1'(b)) mem[wr_addr] <= wr_data;
            end
            assign bank_q[b] = mem[rd_addr];
        end
    endgenerate

    assign rd_data = rd_idx[0] ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/ipba_req_fifo.sv
module ipba_req_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);
    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign valid   = (cnt != '0);
    assign full    = (cnt == (PW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = valid ? mem[rp] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9
endmodule

// File: rtl/ipba_top.sv
module ipba_top
    import ipba_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SLOTS      = 4,
    parameter int PKT_WORDS  = 12,
    parameter int FIFO_DEPTH = 4,
    parameter int DEST_WORD  = 2,
    parameter logic [1:0] PORT_ID = 2'd0,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW = $clog2(PKT_WORDS),
    localparam int RW = $bits(req_rec_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_word,
    output logic              wait_o,
    output logic              err_o,
    input  logic              rel_valid,
    input  logic [SW-1:0]     rel_slot,
    input  logic [SW-1:0]     rd_slot,
    input  logic [CW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic              req_valid,
    output logic [RW-1:0]     req_rec,
    input  logic              req_pop
);
    fsm_e          state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [SW-1:0] cur_slot, cur_slot_n;
    logic [1:0]    cur_dest, cur_dest_n;
    logic          wait_n, err_n;

    logic          alloc, fin, fin_keep, push;
    logic          wr_en;
    logic [SW-1:0] wr_slot;
    logic [CW-1:0] wr_idx;
    logic [SW-1:0] grant;
    logic          free_any, all_held, fifo_full;
    req_rec_t      rec;

    logic start_word;
    assign start_word = in_valid && in_first;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur_slot <= '0;
            cur_dest <= '0;
            wait_o   <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            cur_slot <= cur_slot_n;
            cur_dest <= cur_dest_n;
            wait_o   <= wait_n;
            err_o    <= err_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        cur_slot_n = cur_slot;
        cur_dest_n = cur_dest;
        wait_n     = 1'b0;
        err_n      = 1'b0;
        alloc      = 1'b0;
        fin        = 1'b0;
        fin_keep   = 1'b0;
        push       = 1'b0;
        wr_en      = 1'b0;
        wr_slot    = cur_slot;
        wr_idx     = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start_word) begin
                    if (!free_any) begin
                        err_n = 1'b1;
                    end else begin
                        alloc      = 1'b1;
                        wr_en      = 1'b1;
                        wr_slot    = grant;
                        wr_idx     = '0;
                        cur_slot_n = grant;
                        cnt_n      = CW'(1);
                        state_n    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (start_word) begin
                    wait_n = 1'b1;
                end else if (in_valid) begin
                    wr_en = 1'b1;
                    if (cnt == CW'(DEST_WORD)) cur_dest_n = in_word[1:0];
                    if (cnt == CW'(PKT_WORDS - 1)) begin
                        state_n = ST_COMMIT;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_COMMIT: begin
                if (start_word) wait_n = 1'b1;
                fin      = 1'b1;
                fin_keep = (cur_dest != DEST_INVALID);
                push     = fin_keep;
                cnt_n    = '0;
                state_n  = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign rec.dest = cur_dest;
    assign rec.port = PORT_ID;
    assign rec.slot = 2'(cur_slot);

    ipba_slot_alloc #(.SLOTS(SLOTS)) i_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (alloc),
        .fin      (fin),
        .fin_keep (fin_keep),
        .fin_slot (cur_slot),
        .rel_valid(rel_valid),
        .rel_slot (rel_slot),
        .grant    (grant),
        .free_any (free_any),
        .all_held (all_held)
    );

    ipba_bank_store #(.DATA_W(DATA_W), .SLOTS(SLOTS), .PKT_WORDS(PKT_WORDS)) i_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_slot(wr_slot),
        .wr_idx (wr_idx),
        .wr_data(in_word),
        .rd_slot(rd_slot),
        .rd_idx (rd_idx),
        .rd_data(rd_word)
    );

    ipba_req_fifo #(.W(RW), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .din  (rec),
        .pop  (req_pop),
        .dout (req_rec),
        .valid(req_valid),
        .full (fifo_full)
    );

    AST_WAIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wait_o && err_o)); // R6
    AST_ERR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(all_held)); // R7
    AST_REC_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(state == ST_COMMIT)); // R4
    AST_FIFO_NOT_FULL_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && cur_dest != DEST_INVALID) |-> !fifo_full); // R9
endmodule

// File: tb/test_ipba_top.sv
`timescale 1ns/1ps
module test_ipba_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_first = 1'b0;
    logic [15:0] in_word = '0;
    logic        wait_o, err_o;
    logic        rel_valid = 1'b0;
    logic [1:0]  rel_slot = '0;
    logic [1:0]  rd_slot = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_word;
    logic        req_valid;
    logic [5:0]  req_rec;
    logic        req_pop = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ipba_top i_ipba_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_word(in_word), .wait_o(wait_o), .err_o(err_o),
        .rel_valid(rel_valid), .rel_slot(rel_slot), .rd_slot(rd_slot),
        .rd_idx(rd_idx), .rd_word(rd_word), .req_valid(req_valid),
        .req_rec(req_rec), .req_pop(req_pop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pkt_word(input int seed, input int k, input logic [1:0] dest);
        logic [15:0] w;
        w = {4'hA, 4'(seed), 4'h0, 4'(k)};
        if (k == 2) w[1:0] = dest;
        return w;
    endfunction

    // sends 12 words; inject_at>0 inserts a refused start word before word inject_at
    task automatic send_pkt(input int seed, input logic [1:0] dest, input int inject_at);
        for (int k = 0; k < 12; k++) begin
            if (k == inject_at && k > 0) begin
                in_valid = 1'b1; in_first = 1'b1; in_word = 16'hDEAD;
                @(negedge clk);
                check("R6 wait pulse", wait_o, 1);
            end
            in_valid = 1'b1;
            in_first = (k == 0);
            in_word  = pkt_word(seed, k, dest);
            @(negedge clk);
            if (k == inject_at + 1 && inject_at > 0) check("R6 wait one cycle", wait_o, 0);
        end
        in_valid = 1'b0; in_first = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_slot(input string req, input int slot, input int seed, input logic [1:0] dest);
        int bad = 0;
        for (int k = 0; k < 12; k++) begin
            rd_slot = 2'(slot); rd_idx = 4'(k);
            #0.1;
            if (rd_word !== pkt_word(seed, k, dest)) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic t_reset;
        check("R1 req_valid", req_valid, 0);
        check("R1 req_rec", req_rec, 0);
        check("R1 wait/err", {wait_o, err_o}, 0);
    endtask

    task automatic t_basic;
        send_pkt(1, 2'd1, 0);
        check("R4 record valid", req_valid, 1);
        check("R2 R4 record slot0 dest1", req_rec, 6'b01_00_00);
        check_slot("R3 slot0 words", 0, 1, 2'd1);
    endtask

    task automatic t_idle_noise;
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1; in_first = 1'b0; in_word = 16'hBEEF;
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 no flags", {wait_o, err_o}, 0);
        send_pkt(2, 2'd2, 0);
        check_slot("R10 R2 slot1 words clean", 1, 2, 2'd2);
    endtask

    task automatic t_wait;
        send_pkt(3, 2'd0, 5);
        check_slot("R6 slot2 intact", 2, 3, 2'd0);
    endtask

    task automatic t_fifo_order;
        logic [5:0] exp [3] = '{6'b01_00_00, 6'b10_00_01, 6'b00_00_10};
        for (int i = 0; i < 3; i++) begin
            check("R9 fifo order", req_rec, exp[i]);
            req_pop = 1'b1;
            @(negedge clk);
            req_pop = 1'b0;
        end
        check("R9 fifo empty", req_valid, 0);
    endtask

    task automatic t_discard;
        send_pkt(4, 2'd3, 0);
        check("R5 no record", req_valid, 0);
        send_pkt(5, 2'd0, 0);
        check("R5 slot3 reused", req_rec, 6'b00_00_11);
    endtask

    task automatic t_full;
        in_valid = 1'b1; in_first = 1'b1; in_word = 16'h1234;
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        check("R7 err pulse", err_o, 1);
        @(negedge clk);
        check("R7 err one cycle", err_o, 0);
        check("R7 nothing queued", req_rec, 6'b00_00_11);
        check_slot("R7 slot0 untouched", 0, 1, 2'd1);
    endtask

    task automatic t_release;
        req_pop = 1'b1;
        @(negedge clk);
        req_pop = 1'b0;
        rel_valid = 1'b1; rel_slot = 2'd1;
        @(negedge clk);
        rel_valid = 1'b0;
        send_pkt(6, 2'd2, 0);
        check("R8 released slot1 claimed", req_rec, 6'b10_00_01);
        check_slot("R8 slot1 new words", 1, 6, 2'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_idle_noise();
        t_wait();
        t_fifo_order();
        t_discard();
        t_full();
        t_release();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule